// File: doc/BRIEF.md
# Boot-Block Flash Read-Mode Controller

This block models the read side of a small parallel boot-block flash device. It decodes four active-low control pins: chip select, read enable, write strobe, and a combined reset/power-down pin. From these it chooses one of five conditions: reading the memory array, reading the identifier codes, reading the status byte, standby, or deep power-down. It drives an 8-bit data bus, split into a data value and a drive-enable, from a 17-bit address. The storage is a register array that is loaded with a fixed, computed pattern at reset. The array repeats (aliases) across the address space.

The identifier codes can be reached in two ways. One is a command byte written to the command register. The other is a digital flag that stands in for a high-voltage detector on an address line. Reset, and every interval with the power-down pin low, return the block to array reads. All pins are sampled on the clock, and the bus reflects the pins one clock later. The drive-enable is therefore registered, and it is never raised from a cycle in which the write strobe was low.

Top module: `bbf_read_ctrl`

## Requirements
- R1: While `rst` is high, the bus is not driven, and after reset the block is in array-read mode.
- R2: `bus_drive` is 1 in a cycle only if, at the previous clock edge, `chip_sel_n`=0, `rd_en_n`=0, `wr_strobe_n`=1 and `pwr_rst_n`=1; otherwise it is 0 and `bus_dout` is 0x00. `bus_dout` is valid in the same cycle that `bus_drive` is 1.
- R3: With `chip_sel_n`=1 (standby) the bus is not driven, whatever the state of `rd_en_n`.
- R4: With `pwr_rst_n`=0 the bus is not driven, the mode is forced to array read, and command writes are dropped. The first read after `pwr_rst_n` returns high gives array data.
- R5: An array read of `mem_addr` returns (i*37+11) mod 256, where i = `mem_addr` mod ARRAY_WORDS (default 256).
- R6: A command is taken from `bus_din` at a clock edge where `wr_strobe_n`=1, `wr_strobe_n` was 0 at the previous edge, and `chip_sel_n`=0. The byte 0x90 selects identifier mode, 0x70 selects status mode and 0xFF selects array mode. Any other byte, or any strobe with `chip_sel_n`=1, leaves the mode unchanged.
- R7: In identifier mode, address 0 reads 0x31 and address 1 reads the device code: 0x94 when BOTTOM_BOOT=0, 0x95 when BOTTOM_BOOT=1. Every other address reads 0x00.
- R8: In status mode, every address reads 0x80 (bit 7 = ready, always 1; the other bits are 0).
- R9: A read with `hv_id_req`=1 and `mem_addr[16:1]`=0 returns the identifier code for `mem_addr[0]`, whatever the mode. When `mem_addr[16:1]`≠0, the flag has no effect.
- R10: `prog_volt_ok` has no effect on any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pwr_rst_n | input | 1 | Low: deep power-down and mode reset |
| chip_sel_n | input | 1 | Low: device selected; high: standby |
| rd_en_n | input | 1 | Low: output read enable |
| wr_strobe_n | input | 1 | Command write strobe; capture on its rise |
| prog_volt_ok | input | 1 | Programming supply indication; ignored for reads |
| hv_id_req | input | 1 | Stand-in for the high-voltage identifier detector |
| mem_addr | input | 17 | Byte address |
| bus_din | input | 8 | Data bus, inbound (command bytes) |
| bus_dout | output | 8 | Data bus, outbound value |
| bus_drive | output | 1 | Tri-state enable for `bus_dout` |

## Verification
The assertions assume that every control pin and the address are synchronous to `clk` and settle between edges. They also assume that `bus_din` is stable in the cycle where the write strobe rises. The bench drives every input on the falling edge and holds `bus_din` from the strobe's fall until after its rise. It returns chip select, read enable and write strobe to idle between scenarios, so no property sees a half-changed pin set. Every write in the bench is made with the read enable high. The one write-strobe-low read case uses a command byte that the block ignores.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_IDENT  = 2'd1,
        MD_STATUS = 2'd2
    } mode_e;

    localparam byte_t CMD_IDENT  = 8'h90;
    localparam byte_t CMD_STATUS = 8'h70;
    localparam byte_t CMD_ARRAY  = 8'hFF;

    localparam byte_t MFR_CODE   = 8'h31;
    localparam byte_t DEV_TOP    = 8'h94;
    localparam byte_t DEV_BOTTOM = 8'h95;
    localparam byte_t STATUS_RDY = 8'h80;

    function automatic byte_t dev_code(input bit bottom);
        return bottom ? DEV_BOTTOM : DEV_TOP;
    endfunction

    function automatic byte_t preload(input int unsigned idx);
        int unsigned v;
        v = idx * 37 + 11;
        return byte_t'(v & 255);
    endfunction

    function automatic mode_e decode_cmd(input byte_t c, input mode_e cur);
        case (c)
            CMD_IDENT:  return MD_IDENT;
            CMD_STATUS: return MD_STATUS;
            CMD_ARRAY:  return MD_ARRAY;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/bbf_cmd_ctrl.sv
module bbf_cmd_ctrl
    import bbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwr_rst_n,
    input  logic  chip_sel_n,
    input  logic  wr_strobe_n,
    input  byte_t cmd_in,
    output mode_e mode_q
);
    logic strobe_prev_q;
    logic strobe_rise;

    assign strobe_rise = wr_strobe_n && !strobe_prev_q && !chip_sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev_q <= 1'b1;
        end else begin
            strobe_prev_q <= wr_strobe_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_rst_n) begin
            mode_q <= MD_ARRAY;
        end else if (strobe_rise) begin
            mode_q <= decode_cmd(cmd_in, mode_q);
        end
    end
endmodule

// File: rtl/bbf_array_store.sv
module bbf_array_store
    import bbf_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output byte_t            rdata
);
    byte_t mem_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= preload(i);
            end
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/bbf_read_mux.sv
module bbf_read_mux
    import bbf_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter bit BOTTOM_BOOT = 1'b0
) (
    input  mode_e             mode,
    input  logic              hv_id_req,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             array_data,
    output byte_t             rdata
);
    logic  hv_sel;
    mode_e eff_mode;
    byte_t ident_data;

    assign hv_sel   = hv_id_req && (addr[ADDR_W-1:1] == '0);
    assign eff_mode = hv_sel ? MD_IDENT : mode;

    always_comb begin
        if (addr == ADDR_W'(0)) begin
            ident_data = MFR_CODE;
        end else if (addr == ADDR_W'(1)) begin
            ident_data = dev_code(BOTTOM_BOOT);
        end else begin
            ident_data = 8'h00;
        end
    end

    always_comb begin
        case (eff_mode)
            MD_IDENT:  rdata = ident_data;
            MD_STATUS: rdata = STATUS_RDY;
            default:   rdata = array_data;
        endcase
    end
endmodule

// File: rtl/bbf_out_stage.sv
module bbf_out_stage
    import bbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_ok,
    input  byte_t rdata,
    output byte_t bus_dout,
    output logic  bus_drive
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_drive <= 1'b0;
            bus_dout  <= 8'h00;
        end else begin
            bus_drive <= rd_ok;
            bus_dout  <= rd_ok ? rdata : 8'h00;
        end
    end
endmodule

// File: rtl/bbf_read_ctrl.sv
module bbf_read_ctrl
    import bbf_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int ARRAY_WORDS = 256,
    parameter bit BOTTOM_BOOT = 1'b0,
    localparam int IDX_W = (ARRAY_WORDS > 1) ? $clog2(ARRAY_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_rst_n,
    input  logic              chip_sel_n,
    input  logic              rd_en_n,
    input  logic              wr_strobe_n,
    input  logic              prog_volt_ok,
    input  logic              hv_id_req,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_drive
);
    mode_e mode_q;
    byte_t array_data;
    byte_t rdata;
    logic  rd_ok;
    logic  unused_inputs;

    // The programming supply plays no part in reads.
    assign unused_inputs = prog_volt_ok;

    assign rd_ok = pwr_rst_n && !chip_sel_n && !rd_en_n && wr_strobe_n;

    bbf_cmd_ctrl u_cmd (
        .clk         (clk),
        .rst         (rst),
        .pwr_rst_n   (pwr_rst_n),
        .chip_sel_n  (chip_sel_n),
        .wr_strobe_n (wr_strobe_n),
        .cmd_in      (bus_din),
        .mode_q      (mode_q)
    );

    bbf_array_store #(.WORDS(ARRAY_WORDS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .idx   (mem_addr[IDX_W-1:0]),
        .rdata (array_data)
    );

    bbf_read_mux #(.ADDR_W(ADDR_W), .BOTTOM_BOOT(BOTTOM_BOOT)) u_mux (
        .mode       (mode_q),
        .hv_id_req  (hv_id_req),
        .addr       (mem_addr),
        .array_data (array_data),
        .rdata      (rdata)
    );

    bbf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .rd_ok     (rd_ok),
        .rdata     (rdata),
        .bus_dout  (bus_dout),
        .bus_drive (bus_drive)
    );
endmodule

// File: rtl/bbf_read_ctrl_chk.sv
module bbf_read_ctrl_chk
    import bbf_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_rst_n,
    input logic              chip_sel_n,
    input logic              rd_en_n,
    input logic              wr_strobe_n,
    input logic              hv_id_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        bus_din,
    input logic [7:0]        bus_dout,
    input logic              bus_drive,
    input mode_e             mode_q
);
    logic strobe_was_low;
    logic hv_sel;
    logic rd_cycle;

    always_ff @(posedge clk) begin
        if (rst) strobe_was_low <= 1'b0;
        else     strobe_was_low <= !wr_strobe_n;
    end

    assign hv_sel   = hv_id_req && (mem_addr[ADDR_W-1:1] == '0);
    assign rd_cycle = pwr_rst_n && !chip_sel_n && !rd_en_n && wr_strobe_n;

    // R3
    standby_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(chip_sel_n) |-> !bus_drive);

    // R4
    pwrdn_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!pwr_rst_n) |-> !bus_drive);

    // R4
    pwrdn_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_rst_n |=> mode_q == MD_ARRAY);

    // R2
    strobe_low_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!wr_strobe_n) |-> !bus_drive);

    // R2
    rd_high_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en_n) |-> (!bus_drive && bus_dout == 8'h00));

    // R6
    status_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_rst_n && !chip_sel_n && wr_strobe_n && strobe_was_low
         && bus_din == CMD_STATUS) |=> mode_q == MD_STATUS);

    // R7
    ident_mfr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_cycle && (mode_q == MD_IDENT || hv_sel)
              && mem_addr == ADDR_W'(0)) |-> bus_dout == MFR_CODE);

    // R8
    status_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_cycle && mode_q == MD_STATUS && !hv_sel)
        |-> bus_dout == STATUS_RDY);
endmodule

bind bbf_read_ctrl bbf_read_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/bbf_read_ctrl_tb.sv
module bbf_read_ctrl_tb_top;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_rst_n = 1'b1;
    logic          chip_sel_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic          wr_strobe_n = 1'b1;
    logic          prog_volt_ok = 1'b0;
    logic          hv_id_req = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    bus_din = 8'h00;
    logic [7:0]    bus_dout;
    logic          bus_drive;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    bbf_read_ctrl dut_i (
        .clk (clk), .rst (rst), .pwr_rst_n (pwr_rst_n),
        .chip_sel_n (chip_sel_n), .rd_en_n (rd_en_n),
        .wr_strobe_n (wr_strobe_n), .prog_volt_ok (prog_volt_ok),
        .hv_id_req (hv_id_req), .mem_addr (mem_addr),
        .bus_din (bus_din), .bus_dout (bus_dout), .bus_drive (bus_drive)
    );

    function automatic logic [7:0] exp_array(input int unsigned a);
        int unsigned i;
        i = a % 256;
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        chip_sel_n = 1'b1; rd_en_n = 1'b1; wr_strobe_n = 1'b1;
        hv_id_req = 1'b0; pwr_rst_n = 1'b1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d,
                           output logic drv);
        @(negedge clk);
        chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_strobe_n = 1'b1; mem_addr = a;
        @(negedge clk);
        d = bus_dout; drv = bus_drive;
        chip_sel_n = 1'b1; rd_en_n = 1'b1;
    endtask

    task automatic write_cmd(input logic [7:0] c, input logic sel_n);
        @(negedge clk);
        chip_sel_n = sel_n; rd_en_n = 1'b1; wr_strobe_n = 1'b0; bus_din = c;
        @(negedge clk);
        wr_strobe_n = 1'b1;
        @(negedge clk);
        chip_sel_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 drive during reset", int'(bus_drive), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 drive after reset", int'(bus_drive), 0);
    endtask

    task automatic t_array();
        logic [7:0] d; logic drv;
        do_read(17'd0, d, drv);
        check("R2 drive on read", int'(drv), 1);
        check("R5 array addr 0", int'(d), int'(exp_array(0)));
        do_read(17'd5, d, drv);
        check("R5 array addr 5", int'(d), int'(exp_array(5)));
        do_read(17'd255, d, drv);
        check("R5 array addr 255", int'(d), int'(exp_array(255)));
        do_read(17'h1_0103, d, drv);
        check("R5 array alias", int'(d), int'(exp_array(32'h1_0103)));
    endtask

    task automatic t_bus_off();
        @(negedge clk);
        chip_sel_n = 1'b1; rd_en_n = 1'b0; mem_addr = 17'd3;
        @(negedge clk);
        check("R3 standby drive", int'(bus_drive), 0);
        chip_sel_n = 1'b0; rd_en_n = 1'b1;
        @(negedge clk);
        check("R2 read enable high drive", int'(bus_drive), 0);
        check("R2 idle data", int'(bus_dout), 0);
        bus_din = 8'h00; rd_en_n = 1'b0; wr_strobe_n = 1'b0;
        @(negedge clk);
        check("R2 strobe low drive", int'(bus_drive), 0);
        wr_strobe_n = 1'b1;
        @(negedge clk);
        check("R2 drive after strobe rises", int'(bus_drive), 1);
        go_idle();
    endtask

    task automatic t_ident_cmd();
        logic [7:0] d; logic drv;
        write_cmd(8'h90, 1'b0);
        do_read(17'd0, d, drv);
        check("R7 manufacturer code", int'(d), 8'h31);
        do_read(17'd1, d, drv);
        check("R7 device code", int'(d), 8'h94);
        do_read(17'd2, d, drv);
        check("R7 other ident addr", int'(d), 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d; logic drv;
        write_cmd(8'h70, 1'b0);
        do_read(17'd0, d, drv);
        check("R8 status addr 0", int'(d), 8'h80);
        do_read(17'h0_4A21, d, drv);
        check("R8 status other addr", int'(d), 8'h80);
        write_cmd(8'h12, 1'b0);
        do_read(17'd9, d, drv);
        check("R6 unknown cmd ignored", int'(d), 8'h80);
        write_cmd(8'hFF, 1'b0);
        do_read(17'd9, d, drv);
        check("R6 array cmd", int'(d), int'(exp_array(9)));
        write_cmd(8'h70, 1'b1);
        do_read(17'd9, d, drv);
        check("R6 deselected write ignored", int'(d), int'(exp_array(9)));
    endtask

    task automatic t_hv();
        logic [7:0] d; logic drv;
        hv_id_req = 1'b1;
        do_read(17'd0, d, drv);
        check("R9 hv manufacturer", int'(d), 8'h31);
        do_read(17'd1, d, drv);
        check("R9 hv device", int'(d), 8'h94);
        do_read(17'h0_0201, d, drv);
        check("R9 hv upper bits set", int'(d), int'(exp_array(32'h201)));
        hv_id_req = 1'b0;
        do_read(17'd1, d, drv);
        check("R9 hv released", int'(d), int'(exp_array(1)));
    endtask

    task automatic t_pwrdn();
        logic [7:0] d; logic drv;
        write_cmd(8'h90, 1'b0);
        @(negedge clk);
        pwr_rst_n = 1'b0; chip_sel_n = 1'b0; rd_en_n = 1'b0; mem_addr = 17'd0;
        @(negedge clk);
        check("R4 powerdown drive", int'(bus_drive), 0);
        go_idle();
        do_read(17'd0, d, drv);
        check("R4 array after powerdown", int'(d), int'(exp_array(0)));
        @(negedge clk);
        pwr_rst_n = 1'b0;
        go_idle();
        write_cmd(8'h70, 1'b0);
        @(negedge clk);
        pwr_rst_n = 1'b0; chip_sel_n = 1'b0; wr_strobe_n = 1'b0; bus_din = 8'h90;
        @(negedge clk);
        wr_strobe_n = 1'b1;
        @(negedge clk);
        chip_sel_n = 1'b1; pwr_rst_n = 1'b1;
        do_read(17'd2, d, drv);
        check("R4 write dropped in powerdown", int'(d), int'(exp_array(2)));
    endtask

    task automatic t_vpp();
        logic [7:0] d0; logic [7:0] d1; logic drv;
        prog_volt_ok = 1'b0;
        do_read(17'd77, d0, drv);
        prog_volt_ok = 1'b1;
        do_read(17'd77, d1, drv);
        check("R10 supply flag no effect", int'(d1), int'(d0));
        check("R10 value", int'(d1), int'(exp_array(77)));
        prog_volt_ok = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_array();
        t_bus_off();
        t_ident_cmd();
        t_status();
        t_hv();
        t_pwrdn();
        t_vpp();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end
endmodule